// File: doc/BRIEF.md
# DDR2 SDRAM Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM from power-on to a usable state. After a start strobe it holds the clock enable low for a long stabilization delay and then raises it. After a shorter settling delay it drives a fixed series of commands on the chip-select, row-strobe, column-strobe and write-enable lines. These are two precharge-all commands, two refreshes and seven mode-register loads. When the last load has settled it raises a done flag and keeps the command bus idle.

Each of the four mode registers takes a 16-bit payload from an input port. The sequencer overlays the bits that the power-up procedure itself controls: DLL enable, DLL reset and the off-chip-driver calibration field. It also clears the three top address bits and the top bank bit. Delays are parameters. Those given in nanoseconds are converted to clock cycles from the clock period parameter, rounding up. Those given in cycles are used directly. Any spacing below two cycles is raised to two, so one idle cycle always separates two commands.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is low at a clock edge, and afterwards until a start strobe arrives, cke is low, the command nibble {cs_n,ras_n,cas_n,we_n} is NOP (4'b0111), ba and addr are zero and done is low.
- R2: cke rises on the PWR_CYC-th clock edge after the edge that samples start, and stays high until reset.
- R3: CKE_CYC cycles after cke rises, a precharge-all is issued: nibble 4'b0010 with addr bit 10 high and all other addr and ba bits zero.
- R4: The commands issued are, in this order: precharge-all, load with ba=2, load with ba=3, load with ba=1, load with ba=0, precharge-all, refresh (4'b0001), refresh, load with ba=0, load with ba=1, load with ba=1. A load is nibble 4'b0000.
- R5: Every load drives addr[15:13]=0 and ba[2]=0. Bits [12:0] come from the payload, with these bits forced. The first ba=1 load has bit 0=0 and bits [9:7]=000. The first ba=0 load has bit 8=1. The second ba=0 load has bit 8=0. The second ba=1 load has bit 0=0 and bits [9:7]=111. The third ba=1 load has bit 0=0 and bits [9:7]=000.
- R6: Consecutive commands are spaced exactly as follows. RP_CYC follows a precharge-all. MRD_CYC follows each load, except DLL_CYC after the ba=0 load with bit 8 set. RFC_CYC follows each refresh.
- R7: Every cycle between commands carries NOP with ba and addr zero.
- R8: done rises MRD_CYC cycles after the final load and stays high until reset, with NOP on the bus.
- R9: A start strobe while the sequence runs, or after done, has no effect on timing, commands or done.
- R10: Reset applied mid-sequence returns the block to idle with cke low. It stays idle until a new start strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the sequence when idle |
| mr_val | input | 16 | Payload for the mode register (ba=0) |
| emr1_val | input | 16 | Payload for extended mode register 1 (ba=1) |
| emr2_val | input | 16 | Payload for extended mode register 2 (ba=2) |
| emr3_val | input | 16 | Payload for extended mode register 3 (ba=3) |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address, selects the mode register on loads |
| addr | output | 16 | Address, carries the load payload |
| done | output | 1 | Sequence complete |

## Verification
The assertions assume the spacing parameters are at least two cycles. They also assume payloads are static while a load is on the bus. The bench changes payloads only while the block is idle or in reset. The stream checks assume start is a single-cycle pulse. The bench pulses it once at launch and once more as a stray strobe during the run or after done. Several payload patterns (all ones, all zeros, alternating) show that the forced bits override the inputs and that the other bits pass through.

// File: rtl/ddr2_init_pkg.sv
// Shared encodings for the DDR2 power-up sequencer.
// Assumes command pins are active low, in the order cs_n, ras_n, cas_n, we_n.
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        CMD_LOAD  = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111
    } ddr_cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PWR,
        SQ_SETTLE,
        SQ_ISSUE,
        SQ_GAP,
        SQ_DONE
    } seq_state_t;

    localparam int NUM_STEPS   = 11;
    localparam int STEP_W      = $clog2(NUM_STEPS);
    localparam int ADDR_W      = 16;
    localparam int BANK_W      = 3;
    localparam int PRE_ALL_BIT = 10;
    localparam int DLL_RST_BIT = 8;
    localparam int DLL_OFF_BIT = 0;
    localparam int OCD_LSB     = 7;

endpackage

// File: rtl/ddr2_wait_timer.sv
// Loadable down-counter used for every delay of the sequencer.
// Assumes load and the count value are held only for one cycle each.
// idle_o is high when the count has reached zero.
module ddr2_wait_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          idle_o
);

    logic [CW-1:0] cnt_q;

    // Load a new delay or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign idle_o = (cnt_q == '0);

    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/ddr2_step_decode.sv
// Maps a step index of the power-up sequence to its command, bank,
// address and the spacing to the following command.
// Assumes spacing values are already clamped to at least two cycles.
module ddr2_step_decode
    import ddr2_init_pkg::*;
#(
    parameter int CW     = 16,
    parameter int SP_RP  = 2,
    parameter int SP_MRD = 2,
    parameter int SP_DLL = 2,
    parameter int SP_RFC = 2
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [ADDR_W-1:0] mr_i,
    input  logic [ADDR_W-1:0] emr1_i,
    input  logic [ADDR_W-1:0] emr2_i,
    input  logic [ADDR_W-1:0] emr3_i,
    output ddr_cmd_t          cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CW-1:0]     gap_o
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(16'h1FFF);
    localparam logic [ADDR_W-1:0] OCD_MASK = ADDR_W'(3) << (OCD_LSB - 1) | ADDR_W'(1) << (OCD_LSB + 2);
    localparam logic [ADDR_W-1:0] OCD_ALL  = ADDR_W'(7) << OCD_LSB;
    localparam logic [ADDR_W-1:0] DLL_RST  = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] DLL_OFF  = ADDR_W'(1) << DLL_OFF_BIT;

    logic [ADDR_W-1:0] e1_base;
    logic [ADDR_W-1:0] mr_base;

    // Payload bits [12:0] only; extended-1 base has DLL on and calibration field cleared.
    always_comb begin
        e1_base = emr1_i & LOW_MASK & ~OCD_ALL & ~DLL_OFF;
        mr_base = mr_i & LOW_MASK;
    end

    // Step table of the power-up order.
    always_comb begin
        cmd_o  = CMD_LOAD;
        ba_o   = '0;
        addr_o = '0;
        gap_o  = CW'(SP_MRD - 2);
        case (step_i)
            STEP_W'(0), STEP_W'(5): begin
                cmd_o  = CMD_PRE;
                addr_o = ADDR_W'(1) << PRE_ALL_BIT;
                gap_o  = CW'(SP_RP - 2);
            end
            STEP_W'(1): begin
                ba_o   = BANK_W'(2);
                addr_o = emr2_i & LOW_MASK;
            end
            STEP_W'(2): begin
                ba_o   = BANK_W'(3);
                addr_o = emr3_i & LOW_MASK;
            end
            STEP_W'(3), STEP_W'(10): begin
                ba_o   = BANK_W'(1);
                addr_o = e1_base;
            end
            STEP_W'(4): begin
                addr_o = mr_base | DLL_RST;
                gap_o  = CW'(SP_DLL - 2);
            end
            STEP_W'(6), STEP_W'(7): begin
                cmd_o  = CMD_REF;
                gap_o  = CW'(SP_RFC - 2);
            end
            STEP_W'(8): begin
                addr_o = mr_base & ~DLL_RST;
            end
            STEP_W'(9): begin
                ba_o   = BANK_W'(1);
                addr_o = e1_base | OCD_ALL;
            end
            default: begin
                cmd_o  = CMD_NOP;
            end
        endcase
    end

    logic unused_mask;
    assign unused_mask = ^OCD_MASK;

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up sequencer top. After start it waits the power delay,
// raises cke, waits the settle delay, then steps through the command
// table with the spacing each step demands, and finally holds done.
// Assumes payload inputs are stable while the sequence runs.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_PS  = 5000,
    parameter int PWR_NS  = 200000,
    parameter int CKE_NS  = 400,
    parameter int RP_NS   = 15,
    parameter int RFC_NS  = 128,
    parameter int MRD_CYC = 2,
    parameter int DLL_CYC = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] mr_val,
    input  logic [15:0] emr1_val,
    input  logic [15:0] emr2_val,
    input  logic [15:0] emr3_val,
    output logic        cke,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [2:0]  ba,
    output logic [15:0] addr,
    output logic        done
);

    localparam int PWR_RAW = (PWR_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int CKE_RAW = (CKE_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RP_RAW  = (RP_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RFC_RAW = (RFC_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int PWR_C   = (PWR_RAW < 1) ? 1 : PWR_RAW;
    localparam int CKE_C   = (CKE_RAW < 1) ? 1 : CKE_RAW;
    localparam int SP_RP   = (RP_RAW < 2) ? 2 : RP_RAW;
    localparam int SP_RFC  = (RFC_RAW < 2) ? 2 : RFC_RAW;
    localparam int SP_MRD  = (MRD_CYC < 2) ? 2 : MRD_CYC;
    localparam int SP_DLL0 = (DLL_CYC < 2) ? 2 : DLL_CYC;
    localparam int SP_DLL  = (SP_DLL0 < SP_MRD) ? SP_MRD : SP_DLL0;
    localparam int MAX_A   = (PWR_C > CKE_C) ? PWR_C : CKE_C;
    localparam int MAX_B   = (SP_RP > SP_RFC) ? SP_RP : SP_RFC;
    localparam int MAX_C   = (SP_DLL > MAX_B) ? SP_DLL : MAX_B;
    localparam int MAX_ALL = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CW      = $clog2(MAX_ALL + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic              cke_q;
    logic              tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              tmr_idle;
    ddr_cmd_t          step_cmd;
    logic [BANK_W-1:0] step_ba;
    logic [ADDR_W-1:0] step_addr;
    logic [CW-1:0]     step_gap;
    ddr_cmd_t          bus_cmd;

    ddr2_wait_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .idle_o     (tmr_idle)
    );

    ddr2_step_decode #(
        .CW     (CW),
        .SP_RP  (SP_RP),
        .SP_MRD (SP_MRD),
        .SP_DLL (SP_DLL),
        .SP_RFC (SP_RFC)
    ) u_decode (
        .step_i (step_q),
        .mr_i   (mr_val),
        .emr1_i (emr1_val),
        .emr2_i (emr2_val),
        .emr3_i (emr3_val),
        .cmd_o  (step_cmd),
        .ba_o   (step_ba),
        .addr_o (step_addr),
        .gap_o  (step_gap)
    );

    // Choose which delay the timer loads on a state change.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            SQ_IDLE:   if (start)    begin tmr_load = 1'b1; tmr_val = CW'(PWR_C - 1); end
            SQ_PWR:    if (tmr_idle) begin tmr_load = 1'b1; tmr_val = CW'(CKE_C - 1); end
            SQ_ISSUE:  begin tmr_load = 1'b1; tmr_val = step_gap; end
            default:   ;
        endcase
    end

    // Sequence state, step index and clock-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            cke_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE:   if (start) state_q <= SQ_PWR;
                SQ_PWR:    if (tmr_idle) begin
                               state_q <= SQ_SETTLE;
                               cke_q   <= 1'b1;
                           end
                SQ_SETTLE: if (tmr_idle) begin
                               state_q <= SQ_ISSUE;
                               step_q  <= '0;
                           end
                SQ_ISSUE:  state_q <= SQ_GAP;
                SQ_GAP:    if (tmr_idle) begin
                               if (step_q == LAST_STEP) begin
                                   state_q <= SQ_DONE;
                               end else begin
                                   state_q <= SQ_ISSUE;
                                   step_q  <= step_q + STEP_W'(1);
                               end
                           end
                default:   state_q <= SQ_DONE;
            endcase
        end
    end

    // Drive the bus: the step command for one cycle, NOP otherwise.
    always_comb begin
        if (state_q == SQ_ISSUE) begin
            bus_cmd = step_cmd;
            ba      = step_ba;
            addr    = step_addr;
        end else begin
            bus_cmd = CMD_NOP;
            ba      = '0;
            addr    = '0;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = bus_cmd;
    assign cke  = cke_q;
    assign done = (state_q == SQ_DONE);

    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);
    a_r3_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_NOP) |-> cke);
    a_r5_load_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_LOAD) |-> (addr[15:13] == 3'b000 && !ba[2]));
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_NOP) |=> (bus_cmd == CMD_NOP));
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_cmd == CMD_NOP));
    a_r10_idle_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE) |-> !cke_q);

endmodule

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;

    localparam int P_PWR = 20;
    localparam int P_CKE = 6;
    localparam int P_RP  = 3;
    localparam int P_MRD = 2;
    localparam int P_DLL = 12;
    localparam int P_RFC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mr_val = '0, emr1_val = '0, emr2_val = '0, emr3_val = '0;
    logic        cke, cs_n, ras_n, cas_n, we_n, done;
    logic [2:0]  ba;
    logic [15:0] addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ddr2_init_seq #(
        .CLK_PS(5000), .PWR_NS(100), .CKE_NS(30), .RP_NS(15),
        .RFC_NS(25), .MRD_CYC(P_MRD), .DLL_CYC(P_DLL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mr_val(mr_val), .emr1_val(emr1_val), .emr2_val(emr2_val), .emr3_val(emr3_val),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .done(done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 20000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input int s);
        case (s)
            0, 5:    exp_cmd = 4'b0010;
            6, 7:    exp_cmd = 4'b0001;
            default: exp_cmd = 4'b0000;
        endcase
    endfunction

    function automatic logic [2:0] exp_ba(input int s);
        case (s)
            1:          exp_ba = 3'd2;
            2:          exp_ba = 3'd3;
            3, 9, 10:   exp_ba = 3'd1;
            default:    exp_ba = 3'd0;
        endcase
    endfunction

    function automatic int exp_gap(input int s);
        case (s)
            0, 5:    exp_gap = P_RP;
            4:       exp_gap = P_DLL;
            6, 7:    exp_gap = P_RFC;
            default: exp_gap = P_MRD;
        endcase
    endfunction

    function automatic logic [15:0] exp_addr(input int s, input logic [15:0] m,
                                             input logic [15:0] e1, input logic [15:0] e2,
                                             input logic [15:0] e3);
        logic [15:0] low;
        low = 16'h1FFF;
        case (s)
            0, 5:    exp_addr = 16'h0400;
            1:       exp_addr = e2 & low;
            2:       exp_addr = e3 & low;
            3, 10:   exp_addr = e1 & low & ~16'h0381;
            4:       exp_addr = (m & low) | 16'h0100;
            8:       exp_addr = m & low & ~16'h0100;
            9:       exp_addr = ((e1 & low) & ~16'h0001) | 16'h0380;
            default: exp_addr = 16'h0000;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 cke", {31'd0, cke}, 32'd0);
        check("R1 cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 bus", {13'd0, ba, addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Run one full sequence; stray_k gives a cycle at which start is pulsed again (R9).
    task automatic run_seq(input logic [15:0] m, input logic [15:0] e1,
                           input logic [15:0] e2, input logic [15:0] e3, input int stray_k);
        int issue [11];
        int done_k;
        mr_val = m; emr1_val = e1; emr2_val = e2; emr3_val = e3;
        issue[0] = P_PWR + P_CKE + 1;
        for (int s = 1; s < 11; s++) issue[s] = issue[s-1] + exp_gap(s-1);
        done_k = issue[10] + P_MRD;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= done_k + 6; k++) begin
            int s;
            s = -1;
            for (int j = 0; j < 11; j++) if (issue[j] == k) s = j;
            check("R2 cke", {31'd0, cke}, {31'd0, (k >= P_PWR + 1)});
            check("R8 done", {31'd0, done}, {31'd0, (k >= done_k)});
            if (s < 0) begin
                check("R7 nop", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
                check("R7 idle bus", {13'd0, ba, addr}, 32'd0);
            end else begin
                if (s == 0)
                    check("R3 first precharge", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h2);
                else
                    check("R6 command timing", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, exp_cmd(s)});
                check("R4 bank select", {29'd0, ba}, {29'd0, exp_ba(s)});
                check("R5 payload", {16'd0, addr}, {16'd0, exp_addr(s, m, e1, e2, e3)});
            end
            start = (k == stray_k);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: idle without start stays idle
        repeat (30) @(negedge clk);
        check("R1 no start cke", {31'd0, cke}, 32'd0);

        run_seq(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 40);
        // R9: stray start after done changes nothing
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 done holds", {31'd0, done}, 32'd1);
        check("R9 bus quiet", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);

        do_reset();
        run_seq(16'h0000, 16'h0000, 16'h0000, 16'h0000, 5);
        do_reset();
        run_seq(16'hA5A5, 16'h5A5A, 16'hC3C3, 16'h3C3C, 29);

        // R10: reset mid-sequence
        do_reset();
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        check("R10 cke high before reset", {31'd0, cke}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 cke low", {31'd0, cke}, 32'd0);
        check("R10 cmd nop", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
        check("R10 done low", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R10 stays idle", {31'd0, cke}, 32'd0);
        check("R10 stays quiet", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule